// File: doc/BRIEF.md
# Bus-Watching Privilege Guard

This block lets a processor that has no built-in notion of privilege run untrusted code. It sits beside the processor and watches the instruction-fetch stream, the data bus, the interrupt-acknowledge strobe and the return-from-interrupt indication. From these it keeps a single bit of privilege, user or supervisor. When user code does something it must not do, the block raises a non-maskable interrupt request. The forbidden actions are fetching the interrupt-disable opcode, touching an address outside the windows mapped for it, or writing the guard's own registers.

Access control is done only by address mapping. A small table of inclusive address windows says what user code may reach. There is no graded privilege check on devices. Supervisor software programs the table through a register port. It keeps the interrupt vectors and the handler stack out of every window. Any interrupt puts the block back into supervisor. Supervisor software hands control to user code by arming a control bit. The switch then happens on the next suitable fetch.

Top module: `priv_monitor`

## Requirements
- R1: After reset, `user_mode_o`, `nmi_o` and `sticky_o` are 0, and all windows are invalid. The first user-mode access after reset therefore raises `nmi_o`.
- R2: In user mode, an opcode fetch whose `fetch_data_i` equals the forbidden-opcode register raises `nmi_o`. The register resets to 0xF3.
- R3: A cycle with `irq_ack_i` high makes `user_mode_o` 0 from the next cycle on.
- R4: In user mode, any `reg_we_i` is discarded and raises `nmi_o`.
- R5: In user mode, a data access or a fetch address raises `nmi_o` unless some valid window holds it, with base <= addr <= limit, both bounds inclusive.
- R6: `nmi_o` is a one-cycle pulse, registered one cycle after the violating input. After a pulse, further violations up to and including the next `rti_i` cycle give no pulse and set `sticky_o` instead. Writing control bit 1 in supervisor clears `sticky_o`.
- R7: Writing control bit 0 in supervisor arms the return to user. An armed block enters user on the first `fetch_i` after an `rti_i`, or on a `fetch_i` with `jump_i` high while no interrupt is active (between `irq_ack_i` and `rti_i`). That fetch is checked under user rules, and `user_mode_o` is 1 from the next cycle. Without arming, fetches never change the mode.
- R8: In supervisor, fetches, data accesses and register writes never raise `nmi_o`.
- R9: Register map, with `reg_addr_i` 4 bits wide:
  - Address `{0, idx[1:0], f}` holds the base (f=0) or the limit (f=1) of window idx.
  - Address 8 holds the valid mask, one bit per window.
  - Address 9 holds the forbidden opcode.
  - Address 10 is control: bit 0 arms the return, bit 1 clears the sticky flag.
- R10: A window whose valid bit is 0 grants nothing, even if it is programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| fetch_i | input | 1 | opcode fetch strobe |
| fetch_addr_i | input | 16 | fetch address |
| fetch_data_i | input | 8 | fetched opcode |
| jump_i | input | 1 | current fetch is a jump target |
| bus_valid_i | input | 1 | data access strobe |
| bus_addr_i | input | 16 | data access address |
| irq_ack_i | input | 1 | interrupt acknowledge |
| rti_i | input | 1 | return from interrupt |
| reg_we_i | input | 1 | guard register write |
| reg_addr_i | input | 4 | guard register select |
| reg_wdata_i | input | 16 | guard register write data |
| nmi_o | output | 1 | non-maskable interrupt request pulse |
| user_mode_o | output | 1 | 1 while in user mode |
| sticky_o | output | 1 | violation seen while an NMI was being serviced |

## Verification
The bench sweeps addresses just below, at, and just above each window bound, including a window of a single address and a programmed but invalid window. A comparison off by one at either bound, or a match that ignores the valid bit, shows up as a missing or extra pulse. It covers the entry fetch itself being checked, a jump taken while an interrupt is active, and a return-from-interrupt taken before arming. A design that switched at the wrong moment would let a violating fetch through, or enter user mode early. It also drives a second violation before the return from the NMI and a user write to the valid mask. A wrong design would repeat the pulse instead of setting the sticky flag, or would let user code widen its own map.

// File: rtl/priv_mon_pkg.sv
package priv_mon_pkg;
  localparam int unsigned SEL_VALID  = 0;
  localparam int unsigned SEL_OPCODE = 1;
  localparam int unsigned SEL_CTRL   = 2;
  localparam int unsigned CTRL_ARM   = 0;
  localparam int unsigned CTRL_CLR   = 1;
endpackage

// File: rtl/priv_win_table.sv
module priv_win_table #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NWIN = 4,
  localparam int unsigned IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bnd_we_i,
  input  logic [IW-1:0] bnd_idx_i,
  input  logic          bnd_lim_i,
  input  logic          vld_we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [AW-1:0] chk_f_addr_i,
  input  logic [AW-1:0] chk_d_addr_i,
  output logic          hit_f_o,
  output logic          hit_d_o
);
  logic [AW-1:0]   base_q [NWIN];
  logic [AW-1:0]   lim_q  [NWIN];
  logic [NWIN-1:0] vld_q;
  logic [NWIN-1:0] hf, hd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (vld_we_i) vld_q <= wdata_i[NWIN-1:0];
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end else if (bnd_we_i && bnd_idx_i == IW'(i)) begin
        if (bnd_lim_i) lim_q[i] <= wdata_i;
        else           base_q[i] <= wdata_i;
      end
    end
    assign hf[i] = vld_q[i] && chk_f_addr_i >= base_q[i] && chk_f_addr_i <= lim_q[i];
    assign hd[i] = vld_q[i] && chk_d_addr_i >= base_q[i] && chk_d_addr_i <= lim_q[i];
  end

  assign hit_f_o = |hf;
  assign hit_d_o = |hd;
endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_i,
  input  logic jump_i,
  input  logic irq_ack_i,
  input  logic rti_i,
  input  logic arm_set_i,
  output logic user_o,
  output logic enter_o
);
  logic user_q, arm_q, ret_pend_q, in_irq_q;

  assign enter_o = !user_q && arm_q && fetch_i && !irq_ack_i &&
                   (ret_pend_q || (jump_i && !in_irq_q));
  assign user_o  = user_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      user_q     <= 1'b0;
      arm_q      <= 1'b0;
      ret_pend_q <= 1'b0;
      in_irq_q   <= 1'b0;
    end else begin
      if (irq_ack_i)    user_q <= 1'b0;
      else if (enter_o) user_q <= 1'b1;

      if (enter_o)        arm_q <= 1'b0;
      else if (arm_set_i) arm_q <= 1'b1;

      if (rti_i)        ret_pend_q <= 1'b1;
      else if (fetch_i) ret_pend_q <= 1'b0;

      if (irq_ack_i)  in_irq_q <= 1'b1;
      else if (rti_i) in_irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/priv_nmi_gen.sv
module priv_nmi_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic viol_i,
  input  logic rti_i,
  input  logic clr_i,
  output logic nmi_o,
  output logic sticky_o
);
  logic nmi_q, busy_q, sticky_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q    <= 1'b0;
      busy_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      nmi_q <= viol_i && !busy_q;
      if (viol_i && !busy_q) busy_q <= 1'b1;
      else if (rti_i)        busy_q <= 1'b0;
      if (viol_i && busy_q)  sticky_q <= 1'b1;
      else if (clr_i)        sticky_q <= 1'b0;
    end
  end

  assign nmi_o    = nmi_q;
  assign sticky_o = sticky_q;
endmodule

// File: rtl/priv_monitor.sv
module priv_monitor #(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 8,
  parameter int unsigned NWIN      = 4,
  parameter logic [7:0]  FORBID_OP = 8'hF3,
  localparam int unsigned IW  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int unsigned RAW = IW + 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fetch_i,
  input  logic [AW-1:0]  fetch_addr_i,
  input  logic [DW-1:0]  fetch_data_i,
  input  logic           jump_i,
  input  logic           bus_valid_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic           irq_ack_i,
  input  logic           rti_i,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [AW-1:0]  reg_wdata_i,
  output logic           nmi_o,
  output logic           user_mode_o,
  output logic           sticky_o
);
  import priv_mon_pkg::*;

  logic          user, enter, eff_user, wr_ok, spec;
  logic          hit_f, hit_d, viol;
  logic [DW-1:0] op_q;

  assign eff_user = user | enter;
  assign wr_ok    = reg_we_i && !eff_user;
  assign spec     = reg_addr_i[RAW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= DW'(FORBID_OP);
    else if (wr_ok && spec && reg_addr_i[1:0] == 2'(SEL_OPCODE))
      op_q <= reg_wdata_i[DW-1:0];
  end

  priv_win_table #(.AW(AW), .NWIN(NWIN)) u_tbl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bnd_we_i     (wr_ok && !spec),
    .bnd_idx_i    (reg_addr_i[IW:1]),
    .bnd_lim_i    (reg_addr_i[0]),
    .vld_we_i     (wr_ok && spec && reg_addr_i[1:0] == 2'(SEL_VALID)),
    .wdata_i      (reg_wdata_i),
    .chk_f_addr_i (fetch_addr_i),
    .chk_d_addr_i (bus_addr_i),
    .hit_f_o      (hit_f),
    .hit_d_o      (hit_d)
  );

  priv_mode_ctrl u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fetch_i   (fetch_i),
    .jump_i    (jump_i),
    .irq_ack_i (irq_ack_i),
    .rti_i     (rti_i),
    .arm_set_i (wr_ok && spec && reg_addr_i[1:0] == 2'(SEL_CTRL) && reg_wdata_i[CTRL_ARM]),
    .user_o    (user),
    .enter_o   (enter)
  );

  // the entering fetch is already judged as user code
  assign viol = eff_user && ((fetch_i && (fetch_data_i == op_q || !hit_f)) ||
                             (bus_valid_i && !hit_d) || reg_we_i);

  priv_nmi_gen u_nmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .viol_i   (viol),
    .rti_i    (rti_i),
    .clr_i    (wr_ok && spec && reg_addr_i[1:0] == 2'(SEL_CTRL) && reg_wdata_i[CTRL_CLR]),
    .nmi_o    (nmi_o),
    .sticky_o (sticky_o)
  );

  assign user_mode_o = user;
endmodule

// File: rtl/priv_monitor_chk.sv
module priv_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fetch_i,
  input logic irq_ack_i,
  input logic reg_we_i,
  input logic nmi_o,
  input logic user_mode_o,
  input logic sticky_o
);
  p_nmi_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);
  p_sticky_no_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sticky_o) |-> !nmi_o);
  p_irq_to_sup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> !user_mode_o);
  p_user_wr_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_mode_o && reg_we_i |=> (nmi_o || sticky_o));
  p_sup_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_mode_o && !fetch_i |=> !nmi_o);
  p_entry_on_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(user_mode_o) |-> $past(fetch_i));
endmodule

bind priv_monitor priv_monitor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_i     (fetch_i),
  .irq_ack_i   (irq_ack_i),
  .reg_we_i    (reg_we_i),
  .nmi_o       (nmi_o),
  .user_mode_o (user_mode_o),
  .sticky_o    (sticky_o)
);

// File: tb/priv_monitor_tb.sv
module priv_monitor_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fetch_i = 0, jump_i = 0, bus_valid_i = 0, irq_ack_i = 0, rti_i = 0, reg_we_i = 0;
  logic [15:0] fetch_addr_i = 0, bus_addr_i = 0, reg_wdata_i = 0;
  logic [7:0]  fetch_data_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic        nmi_o, user_mode_o, sticky_o;
  int          n_chk = 0, n_bad = 0;

  always #2 clk_i = ~clk_i;

  priv_monitor u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fetch_i = 0; jump_i = 0; bus_valid_i = 0; irq_ack_i = 0; rti_i = 0; reg_we_i = 0;
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
  endtask

  task automatic fetch(input logic [15:0] a, input logic [7:0] op, input logic j);
    fetch_i = 1; fetch_addr_i = a; fetch_data_i = op; jump_i = j;
    step();
  endtask

  task automatic acc(input logic [15:0] a);
    bus_valid_i = 1; bus_addr_i = a;
    step();
  endtask

  task automatic irq();
    irq_ack_i = 1;
    step();
  endtask

  task automatic rti();
    rti_i = 1;
    step();
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [15:0] SWEEP [10] = '{16'h0FFF, 16'h1000, 16'h1080, 16'h10FF, 16'h1100,
                                         16'h1FFF, 16'h2000, 16'h2001, 16'h3000, 16'h3050};

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 user after reset", user_mode_o, 0);
    chk("R1 nmi after reset", nmi_o, 0);
    chk("R1 sticky after reset", sticky_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // empty table: entering fetch violates
    wr(4'd10, 16'h1);
    fetch(16'h1000, 8'h00, 1'b1);
    chk("R7 entry on jump", user_mode_o, 1);
    chk("R1 empty table faults", nmi_o, 1);
    step();
    chk("R6 nmi one cycle", nmi_o, 0);
    irq();
    chk("R3 irq to supervisor", user_mode_o, 0);
    rti();

    wr(4'd0, 16'h1000); wr(4'd1, 16'h10FF);
    wr(4'd2, 16'h2000); wr(4'd3, 16'h2000);
    wr(4'd4, 16'h3000); wr(4'd5, 16'h30FF);
    wr(4'd8, 16'h0003);

    fetch(16'h1000, 8'h00, 1'b1);
    chk("R7 no arm no entry", user_mode_o, 0);
    acc(16'h9000);
    chk("R8 supervisor access quiet", nmi_o, 0);
    wr(4'd10, 16'h1);
    fetch(16'h1000, 8'h00, 1'b1);
    chk("R7 armed jump entry", user_mode_o, 1);
    chk("R5 entry fetch inside", nmi_o, 0);

    for (int k = 0; k < 10; k++) begin
      for (int m = 0; m < 2; m++) begin
        logic [15:0] a;
        logic        e;
        a = SWEEP[k];
        e = !((a >= 16'h1000 && a <= 16'h10FF) || a == 16'h2000);
        if (m == 0) acc(a); else fetch(a, 8'h00, 1'b0);
        if (a >= 16'h3000) chk("R10 invalid window", nmi_o, e);
        else               chk("R5 window bound", nmi_o, e);
        if (e) begin step(); rti(); end
      end
    end
    chk("R5 still user", user_mode_o, 1);

    fetch(16'h1004, 8'hF3, 1'b0);
    chk("R2 default forbidden opcode", nmi_o, 1);
    step(); rti();
    fetch(16'h1004, 8'hF2, 1'b0);
    chk("R2 other opcode allowed", nmi_o, 0);

    acc(16'h5000);
    chk("R6 first violation", nmi_o, 1);
    step();
    chk("R6 pulse ends", nmi_o, 0);
    acc(16'h5000);
    chk("R6 second violation no pulse", nmi_o, 0);
    chk("R6 sticky set", sticky_o, 1);
    irq();
    chk("R3 irq to supervisor", user_mode_o, 0);
    wr(4'd10, 16'h2);
    chk("R6 sticky cleared", sticky_o, 0);
    rti();

    wr(4'd10, 16'h1);
    fetch(16'h1000, 8'h00, 1'b0);
    chk("R7 entry after rti", user_mode_o, 1);
    wr(4'd8, 16'h000F);
    chk("R4 user write faults", nmi_o, 1);
    step(); rti();
    acc(16'h3000);
    chk("R4 user write discarded", nmi_o, 1);
    step(); rti();

    irq();
    fetch(16'h0100, 8'h00, 1'b0);
    wr(4'd10, 16'h1);
    fetch(16'h1000, 8'h00, 1'b1);
    chk("R7 jump during interrupt no entry", user_mode_o, 0);
    rti();
    fetch(16'h1000, 8'h00, 1'b0);
    chk("R7 entry on fetch after rti", user_mode_o, 1);

    irq();
    fetch(16'h0100, 8'h00, 1'b0);
    wr(4'd9, 16'h00FA);
    wr(4'd10, 16'h1);
    rti();
    fetch(16'h1000, 8'h00, 1'b0);
    chk("R9 reentry", user_mode_o, 1);
    fetch(16'h1002, 8'hF3, 1'b0);
    chk("R9 old opcode allowed", nmi_o, 0);
    fetch(16'h1002, 8'hFA, 1'b0);
    chk("R9 new opcode faults", nmi_o, 1);
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule